// File: doc/BRIEF.md
# Carrier-Modulated Remote Control Transmit Framer

This block takes asynchronous characters from a host UART on a single serial line, throws away their start and stop bits, and queues the data bits in a 22-character buffer. It then sends those data bits to an infrared LED driver as one continuous, unframed bit stream. The rate of that stream is set by a divider and is normally much slower than the host line. While a 0 bit is being sent, the LED enable carries a square-wave carrier. During a 1 bit it stays dark.

The host keeps writing characters while earlier ones are still going out. A busy output tells the host to pause when only one free slot remains. A write that arrives with every slot taken is discarded, and a sticky flag records the loss. The block runs from the 3.6864 MHz base clock. The host line is sampled with a one-cycle tick at sixteen times the host baud rate. The bit-rate timer uses a fixed prescale of 16, followed by the programmable divider.

Top module: `crm_ir_tx`

## Requirements
- R1: Each character received on `txd_in` (one low start bit, 8 data bits sent least significant first, one stop bit, with 16 ticks of `baud16_tick` per bit) adds only its 8 data bits to the output stream. They are sent least significant bit first, and characters go out in the order they arrived.
- R2: A character whose stop bit is sampled low is discarded and never transmitted.
- R3: Every transmitted bit lasts exactly 16 × (`bitrate_div` + 1) clock cycles.
- R4: During a 0 bit, `led_on` carries a carrier with a period of `carrier_div` + 1 clocks. It is high for (`carrier_div` >> 1) + 1 clocks of each period. The carrier phase runs on, unbroken, across consecutive 0 bits.
- R5: Buffered characters are sent back to back. Bit 0 of the next character follows bit 7 of the previous one with no idle cycle in between.
- R6: `led_on` is low throughout every 1 bit. It stays low whenever nothing is buffered. Sending starts without waiting for a bit-rate boundary once a character has been stored.
- R7: The buffer holds 22 characters. `busy` is high exactly while 21 or more characters are held, counting the one being sent.
- R8: A character leaves the buffer at the end of its eighth bit. With 21 characters held, `busy` falls in the first cycle after that bit ends.
- R9: A write that finds all 22 slots taken is dropped and leaves the buffer contents unchanged. It sets `overflow`, which stays set until reset.
- R10: After reset, `led_on`, `busy` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (3.6864 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| txd_in | input | 1 | Serial line from the host UART, idle high |
| baud16_tick | input | 1 | One-cycle pulse at 16 times the host baud rate |
| carrier_div | input | 8 | Carrier divider; carrier period is value + 1 clocks |
| bitrate_div | input | 8 | Bit-rate divider; bit period is 16 × (value + 1) clocks |
| led_on | output | 1 | LED enable, high to light the LED |
| busy | output | 1 | Asks the host to stop sending characters |
| overflow | output | 1 | Sticky flag: a character was lost to a full buffer |

## Verification
The assertions assume that both dividers stay constant while a character is being sent. They also assume that `baud16_tick` is a single-cycle pulse, that `txd_in` idles high between characters, and that the host line is at least 20% faster than the infrared bit rate, so that a burst really does reach the serializer before the current character ends. The stimulus fixes both dividers before each burst and changes them only while the output is idle. It pulses the tick on every other clock, so that one host character takes 320 clocks. For streaming bursts it draws the bit-rate divider from a range whose infrared character is longer than that. The fill test uses the slowest bit rate, so that no character leaves while the buffer is being filled.

// File: rtl/crm_pkg.sv
package crm_pkg;

  // width of both programmable dividers
  localparam int unsigned DIV_W    = 8;
  // base clocks per bit-rate step and host ticks per host bit
  localparam int unsigned PRESCALE = 16;
  localparam int unsigned PRE_W    = $clog2(PRESCALE);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  // clocks per transmitted bit for a given divider setting
  function automatic int unsigned bit_period_clks(input logic [DIV_W-1:0] div);
    return PRESCALE * (int'(div) + 1);
  endfunction

  // carrier phase: high for the first (div>>1)+1 counts of each period
  function automatic logic carrier_phase_on(input logic [DIV_W-1:0] cnt,
                                            input logic [DIV_W-1:0] div);
    return cnt <= (div >> 1);
  endfunction

endpackage

// File: rtl/crm_uart_rx.sv
module crm_uart_rx
  import crm_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd_async,
  input  logic                 tick,
  output logic [DATA_BITS-1:0] data,
  output logic                 valid
);

  localparam int unsigned BIDX_W = $clog2(DATA_BITS);
  localparam logic [PRE_W-1:0]  TICK_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [PRE_W-1:0]  TICK_MID  = PRE_W'(PRESCALE / 2 - 1);
  localparam logic [BIDX_W-1:0] BIT_LAST  = BIDX_W'(DATA_BITS - 1);

  logic [1:0]        sync_q;
  logic              rxd;
  rx_state_t         state;
  logic [PRE_W-1:0]  tick_cnt;
  logic [BIDX_W-1:0] bit_cnt;

  assign rxd = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      state    <= RX_IDLE;
      tick_cnt <= '0;
      bit_cnt  <= '0;
      data     <= '0;
      valid    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_async};
      valid  <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rxd) begin
              state    <= RX_START;
              tick_cnt <= '0;
            end
          end
          RX_START: begin
            if (tick_cnt == TICK_MID) begin
              // confirm start bit at its centre, else treat as a glitch
              if (!rxd) begin
                state    <= RX_DATA;
                tick_cnt <= '0;
                bit_cnt  <= '0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (tick_cnt == TICK_LAST) begin
              tick_cnt <= '0;
              data     <= {rxd, data[DATA_BITS-1:1]};
              if (bit_cnt == BIT_LAST) state <= RX_STOP;
              else                     bit_cnt <= bit_cnt + 1'b1;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (tick_cnt == TICK_LAST) begin
              state <= RX_IDLE;
              valid <= rxd;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  a_r1_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r2_write_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(state == RX_STOP));

endmodule

// File: rtl/crm_char_fifo.sv
module crm_char_fifo #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned DEPTH     = 22
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DATA_BITS-1:0]         push_data,
  input  logic                         pop,
  output logic [DATA_BITS-1:0]         head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         overflow
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_BITS-1:0] mem [DEPTH];
  logic [PTR_W-1:0]     wr_ptr, rd_ptr;
  logic                 full, accept, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_FULL);
  assign pop_ok = pop && (count != '0);
  assign accept = push && (!full || pop_ok);
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok) rd_ptr <= ptr_next(rd_ptr);
      count    <= count + CNT_W'(accept) - CNT_W'(pop_ok);
      overflow <= overflow | (push && !accept);
    end
  end

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

endmodule

// File: rtl/crm_ir_serializer.sv
module crm_ir_serializer
  import crm_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 have_char,
  input  logic                 more_after_pop,
  input  logic [DATA_BITS-1:0] cur_char,
  input  logic [DIV_W-1:0]     rate_div,
  input  logic [DIV_W-1:0]     carrier_div,
  output logic                 led,
  output logic                 char_done
);

  localparam int unsigned BIDX_W = $clog2(DATA_BITS);
  localparam logic [BIDX_W-1:0] BIT_LAST = BIDX_W'(DATA_BITS - 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(PRESCALE - 1);

  logic              active;
  logic [BIDX_W-1:0] bit_idx;
  logic [PRE_W-1:0]  pre_cnt;
  logic [DIV_W-1:0]  rate_cnt;
  logic [DIV_W-1:0]  car_cnt;
  logic              pre_wrap, rate_wrap, car_wrap, bit_end, last_bit;

  assign pre_wrap  = (pre_cnt == PRE_LAST);
  assign rate_wrap = (rate_cnt >= rate_div);
  assign car_wrap  = (car_cnt >= carrier_div);
  assign bit_end   = active && pre_wrap && rate_wrap;
  assign last_bit  = (bit_idx == BIT_LAST);
  assign char_done = bit_end && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      bit_idx  <= '0;
      pre_cnt  <= '0;
      rate_cnt <= '0;
      car_cnt  <= '0;
    end else if (!active) begin
      // idle: timers parked at zero, start as soon as a character is held
      bit_idx  <= '0;
      pre_cnt  <= '0;
      rate_cnt <= '0;
      car_cnt  <= '0;
      active   <= have_char;
    end else begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) rate_cnt <= rate_wrap ? '0 : rate_cnt + 1'b1;
      car_cnt <= car_wrap ? '0 : car_cnt + 1'b1;
      if (bit_end) begin
        bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
        if (last_bit && !more_after_pop) active <= 1'b0;
      end
    end
  end

  assign led = active && !cur_char[bit_idx] && carrier_phase_on(car_cnt, carrier_div);

  a_r6_dark_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !led);

  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && more_after_pop) |=> (active && bit_idx == '0));

  a_r3_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bit_end) |=> $stable(bit_idx));

endmodule

// File: rtl/crm_ir_tx.sv
module crm_ir_tx
  import crm_pkg::*;
#(
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned FIFO_DEPTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txd_in,
  input  logic             baud16_tick,
  input  logic [DIV_W-1:0] carrier_div,
  input  logic [DIV_W-1:0] bitrate_div,
  output logic             led_on,
  output logic             busy,
  output logic             overflow
);

  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] BUSY_LEVEL = CNT_W'(FIFO_DEPTH - 1);

  logic [DATA_BITS-1:0] wr_data, head;
  logic                 wr_valid, char_done, more;
  logic [CNT_W-1:0]     fifo_count;

  crm_uart_rx #(.DATA_BITS(DATA_BITS)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd_async (txd_in),
    .tick      (baud16_tick),
    .data      (wr_data),
    .valid     (wr_valid)
  );

  crm_char_fifo #(.DATA_BITS(DATA_BITS), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_valid),
    .push_data (wr_data),
    .pop       (char_done),
    .head      (head),
    .count     (fifo_count),
    .overflow  (overflow)
  );

  assign more = (fifo_count > CNT_W'(1)) || wr_valid;

  crm_ir_serializer #(.DATA_BITS(DATA_BITS)) ser_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .have_char      (fifo_count != '0),
    .more_after_pop (more),
    .cur_char       (head),
    .rate_div       (bitrate_div),
    .carrier_div    (carrier_div),
    .led            (led_on),
    .char_done      (char_done)
  );

  assign busy = (fifo_count >= BUSY_LEVEL);

  a_r8_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == BUSY_LEVEL && char_done && !wr_valid) |=> !busy);

  a_r7_busy_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == BUSY_LEVEL - 1'b1 && wr_valid && !char_done) |=> busy);

endmodule

// File: tb/crm_ir_tx_tb_top.sv
module crm_ir_tx_tb_top;

  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txd = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] cdiv = 8'd6;
  logic [7:0] bdiv = 8'd3;
  logic       led, busy, ovf;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] exp_q [16];
  logic [7:0] got_q [16];

  crm_ir_tx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .txd_in      (txd),
    .baud16_tick (tick),
    .carrier_div (cdiv),
    .bitrate_div (bdiv),
    .led_on      (led),
    .busy        (busy),
    .overflow    (ovf)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick <= ~tick;

  always @(posedge clk) begin
    if (cyc == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected <%0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int period_of(input logic [7:0] d);
    return 16 * (int'(d) + 1);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic send_bit(input logic v);
    txd = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic good_stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(good_stop);
    if (!good_stop) send_bit(1'b1);
  endtask

  // decode nch characters from the LED; checks carrier shape on the way
  task automatic decode_stream(input int nch);
    int p, h, cp, waited, t, last_rise, run;
    logic prev, run_ok, prev_one, any, l;
    p = period_of(bdiv);
    h = int'(cdiv >> 1) + 1;
    cp = int'(cdiv) + 1;
    waited = 0;
    while (!led && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    if (!led) begin
      chk(1'b0, "R1 stream never started", 0, 1);
      return;
    end
    prev = 1'b0; t = 0; last_rise = -1; run = 0; run_ok = 1'b1; prev_one = 1'b0;
    for (int k = 0; k < nch * 8; k++) begin
      any = 1'b0;
      for (int c = 0; c < p; c++) begin
        if (!(k == 0 && c == 0)) @(negedge clk);
        l = led;
        if (l) any = 1'b1;
        if (l && !prev) begin
          run_ok = !(c == 0 && prev_one);
          if (last_rise >= 0 && run_ok)
            chk((t - last_rise) == cp, "R4 carrier period", t - last_rise, cp);
          last_rise = run_ok ? t : -1;
          run = 0;
        end
        if (!l && prev && run_ok && c != 0)
          chk(run == h, "R4 carrier high time", run, h);
        if (l) run++;
        prev = l;
        t++;
      end
      got_q[k / 8][k % 8] = !any;
      if (!any) begin
        prev_one = 1'b1;
        last_rise = -1;
      end else begin
        prev_one = 1'b0;
      end
    end
  endtask

  task automatic check_idle(input int span);
    int lit;
    lit = 0;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (led) lit++;
    end
    chk(lit == 0, "R6 LED dark with empty buffer", lit, 0);
    chk(busy == 1'b0, "R7 busy low when idle", int'(busy), 0);
  endtask

  task automatic run_burst(input int n);
    fork
      begin
        for (int i = 0; i < n; i++) send_char(exp_q[i], 1'b1);
      end
      decode_stream(n);
    join
    for (int i = 0; i < n; i++)
      chk(got_q[i] == exp_q[i], "R1 R3 R5 character content", int'(got_q[i]), int'(exp_q[i]));
    check_idle(2 * period_of(bdiv));
  endtask

  initial begin
    int n, t0, p, tb;
    void'($urandom(32'h0C0FFEE5));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(led == 1'b0, "R10 led after reset", int'(led), 0);
    chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    chk(ovf == 1'b0, "R10 overflow after reset", int'(ovf), 0);
    repeat (40) @(negedge clk);

    // directed: all-zero and all-one characters inside a burst
    bdiv = 8'd3; cdiv = 8'd6;
    exp_q[0] = 8'hA4; exp_q[1] = 8'hFF; exp_q[2] = 8'h00; exp_q[3] = 8'h81;
    run_burst(4);

    // random bursts
    for (int r = 0; r < 4; r++) begin
      bdiv = 8'(3 + $urandom % 4);
      cdiv = 8'($urandom % 31);
      n = 3 + int'($urandom % 4);
      for (int i = 0; i < n; i++) exp_q[i] = 8'($urandom);
      exp_q[0][0] = 1'b0;
      run_burst(n);
    end

    // R2: bad stop bit is discarded, following good character still sent
    bdiv = 8'd3; cdiv = 8'd9;
    exp_q[0] = 8'h5A;
    fork
      begin
        send_char(8'h33, 1'b0);
        send_char(exp_q[0], 1'b1);
      end
      decode_stream(1);
    join
    chk(got_q[0] == exp_q[0], "R2 framing-error character dropped", int'(got_q[0]), int'(exp_q[0]));
    check_idle(2 * period_of(bdiv));

    // R7 R8 R9: fill the buffer at the slowest bit rate
    bdiv = 8'd255; cdiv = 8'd96;
    p = period_of(bdiv);
    t0 = 0;
    fork
      begin
        for (int k = 1; k <= 23; k++) begin
          send_char(8'h00, 1'b1);
          chk(busy == (k >= 21), "R7 busy threshold", int'(busy), int'(k >= 21));
          if (k == 22) chk(ovf == 1'b0, "R9 no overflow at 22", int'(ovf), 0);
          if (k == 23) chk(ovf == 1'b1, "R9 overflow on 23rd write", int'(ovf), 1);
        end
      end
      begin
        while (!led) @(negedge clk);
        t0 = cyc;
      end
    join
    while (cyc < t0 + 8 * p + 4) @(negedge clk);
    chk(busy == 1'b1, "R9 dropped write left buffer full", int'(busy), 1);
    while (busy && cyc < t0 + 16 * p + 200) @(negedge clk);
    tb = cyc - t0;
    chk(tb == 16 * p, "R8 busy falls after character ends", tb, 16 * p);
    repeat (100) @(negedge clk);
    chk(ovf == 1'b1, "R9 overflow sticky", int'(ovf), 1);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ovf == 1'b0, "R10 overflow cleared by reset", int'(ovf), 0);
    chk(busy == 1'b0, "R10 busy cleared by reset", int'(busy), 0);
    chk(led == 1'b0, "R10 led dark after reset", int'(led), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule